// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a 16-bit down-counter that requests an interrupt at a fixed rate. A processor sets it up through three halfword registers on a simple synchronous write/read port: a control/status word, a modulus and a read-only view of the live count. Each count step takes 2^(P+1) clock cycles, where P is the 4-bit prescale field. The counter restarts either from the modulus or from 0xFFFF. Each time it passes zero a sticky flag is set. The interrupt line is the flag gated by an enable bit.

A small run-state machine decides in each cycle whether the prescaler and the counter may advance. Its states are `ST_STOP` (timer disabled), `ST_RUN`, `ST_HALT_DBG` (the debug-halt bit and the debug pin are both set) and `ST_HALT_DOZE` (the doze-halt bit and the doze pin are both set). Every state moves to `ST_STOP` when enable is about to be cleared. From any enabled state the next state is `ST_HALT_DBG` if the debug condition holds. Otherwise it is `ST_HALT_DOZE` if the doze condition holds, and otherwise `ST_RUN`. Debug therefore takes priority over doze. The machine looks at the control value as it will be after the current write, so it changes state on the same edge as the write.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the count does not move.
- R2: Byte offset 0 is control/status, offset 2 is the modulus and offset 4 is the count. Control bits are: 0 enable, 1 reload-from-modulus, 2 flag, 3 interrupt enable, 4 overwrite, 5 debug-halt, 6 doze-halt, 11:8 prescale. Unused control bits and offset 6 read as zero. Writes to offset 4 have no effect.
- R3: While running, the count steps down once every 2^(P+1) clock cycles.
- R4: With reload-from-modulus set to 1 and modulus M, the flag is set once every (M+1) count steps, and the count restarts at M after passing zero.
- R5: With reload-from-modulus set to 0, the count goes from zero to 0xFFFF. A restart in this mode loads 0xFFFF.
- R6: The flag is set on the count step taken while the count is zero.
- R7: Writing control with bit 2 = 1 clears the flag. Writing bit 2 = 0 leaves the flag as it is. No write can set the flag.
- R8: `irq` is high exactly when the interrupt-enable bit and the flag are both 1.
- R9: Any write to the modulus clears the flag.
- R10: A modulus write with overwrite = 1 loads the value into the count on the same edge. With overwrite = 0 the new value is first used at the next reload.
- R11: A control write that changes only interrupt-enable or flag leaves the count and the prescaler untouched. Any other change that leaves the timer enabled reloads the count and clears the prescaler.
- R12: With enable = 0 the count and the prescaler hold their values.
- R13: The count holds while debug-halt = 1 and `dbg_mode` = 1, or while doze-halt = 1 and `doze_mode` = 1. A pin takes effect one cycle after it is sampled.
- R14: If a zero-crossing step and a flag-clearing write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| dbg_mode | input | 1 | System is in debug mode |
| doze_mode | input | 1 | System is in doze mode |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume a well-formed bus:
- `bus_wr` is a one-cycle strobe that targets one register.
- `bus_addr` is always an even offset.
- The mode pins are synchronous to `clk`.

The stimulus keeps within these assumptions. It drives every input on the falling edge, issues a single write per task call, and uses only the offsets 0, 2, 4 and 6. Random prescale and modulus values are kept small, so that several full periods fit into the run. Each random modulus is at least 2, so a flag-clearing write can never land on the next zero crossing by accident. The one case where that collision is wanted is built on purpose, with its cycle counted out.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PRE_W     = 4;
    localparam int B_EN      = 0;
    localparam int B_RLD     = 1;
    localparam int B_FLAG    = 2;
    localparam int B_IE      = 3;
    localparam int B_OVW     = 4;
    localparam int B_DBG     = 5;
    localparam int B_DOZE    = 6;
    localparam int B_PRE_LO  = 8;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_MOD  = 2'd1;
    localparam logic [1:0] IDX_CNT  = 2'd2;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_RUN,
        ST_HALT_DBG,
        ST_HALT_DOZE
    } run_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             rld;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              tc,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nx,
    output logic [CNT_W-1:0]  mod_q,
    output logic              restart,
    output logic [CNT_W-1:0]  load_val,
    output logic              ow_load,
    output logic              irq
);

    logic       flag_q;
    logic       flag_nx;
    logic [1:0] idx;
    logic       even;
    logic       wr_ctrl;
    logic       wr_mod;
    ctrl_t      wr_fields;
    logic       cfg_diff;
    logic       unused_bits;

    assign idx     = addr[2:1];
    assign even    = ~addr[0];
    assign wr_ctrl = wr_en && even && (idx == IDX_CTRL);
    assign wr_mod  = wr_en && even && (idx == IDX_MOD);

    assign unused_bits = ^{wdata[CNT_W-1:B_PRE_LO+PRE_W], wdata[7], addr[ADDR_W-1:2]};

    always_comb begin
        wr_fields      = '0;
        wr_fields.en   = wdata[B_EN];
        wr_fields.rld  = wdata[B_RLD];
        wr_fields.ie   = wdata[B_IE];
        wr_fields.ovw  = wdata[B_OVW];
        wr_fields.dbg  = wdata[B_DBG];
        wr_fields.doze = wdata[B_DOZE];
        wr_fields.pre  = wdata[B_PRE_LO +: PRE_W];
    end

    // Everything but the interrupt enable counts as a configuration change
    assign cfg_diff = {wr_fields.pre, wr_fields.doze, wr_fields.dbg,
                       wr_fields.ovw, wr_fields.rld, wr_fields.en}
                   != {ctrl_q.pre, ctrl_q.doze, ctrl_q.dbg,
                       ctrl_q.ovw, ctrl_q.rld, ctrl_q.en};

    assign restart  = wr_ctrl && cfg_diff && wr_fields.en;
    assign ctrl_nx  = wr_ctrl ? wr_fields : ctrl_q;
    assign load_val = wr_fields.rld ? mod_q : {CNT_W{1'b1}};
    assign ow_load  = wr_mod && ctrl_q.ovw;

    always_comb begin
        flag_nx = flag_q;
        if ((wr_ctrl && wdata[B_FLAG]) || wr_mod) begin
            flag_nx = 1'b0;
        end
        if (tc) begin
            flag_nx = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mod_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nx;
            flag_q <= flag_nx;
            if (wr_mod) begin
                mod_q <= wdata;
            end
        end
    end

    assign irq = ctrl_q.ie & flag_q;

    always_comb begin
        rdata = '0;
        if (even) begin
            unique case (idx)
                IDX_CTRL: begin
                    rdata[B_EN]               = ctrl_q.en;
                    rdata[B_RLD]              = ctrl_q.rld;
                    rdata[B_FLAG]             = flag_q;
                    rdata[B_IE]               = ctrl_q.ie;
                    rdata[B_OVW]              = ctrl_q.ovw;
                    rdata[B_DBG]              = ctrl_q.dbg;
                    rdata[B_DOZE]             = ctrl_q.doze;
                    rdata[B_PRE_LO +: PRE_W]  = ctrl_q.pre;
                end
                IDX_MOD: rdata = mod_q;
                IDX_CNT: rdata = cnt;
                default: rdata = '0;
            endcase
        end
    end

    // R9
    mod_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && !tc) |=> !flag_q);

    // R6
    tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> flag_q);

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tc));

endmodule

// File: rtl/pit_seq.sv
module pit_seq
    import pit_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_nx,
    input  logic  en_q,
    input  logic  dbg_pin,
    input  logic  doze_pin,
    output logic  count_en
);

    run_state_e state_q;
    run_state_e state_nx;
    logic       hold_dbg;
    logic       hold_doze;

    assign hold_dbg  = ctrl_nx.dbg  && dbg_pin;
    assign hold_doze = ctrl_nx.doze && doze_pin;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (ctrl_nx.en) begin
                    if (hold_dbg)       state_nx = ST_HALT_DBG;
                    else if (hold_doze) state_nx = ST_HALT_DOZE;
                    else                state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!ctrl_nx.en)    state_nx = ST_STOP;
                else if (hold_dbg)  state_nx = ST_HALT_DBG;
                else if (hold_doze) state_nx = ST_HALT_DOZE;
            end
            ST_HALT_DBG: begin
                if (!ctrl_nx.en)    state_nx = ST_STOP;
                else if (!hold_dbg) state_nx = hold_doze ? ST_HALT_DOZE : ST_RUN;
            end
            ST_HALT_DOZE: begin
                if (!ctrl_nx.en)     state_nx = ST_STOP;
                else if (hold_dbg)   state_nx = ST_HALT_DBG;
                else if (!hold_doze) state_nx = ST_RUN;
            end
            default: state_nx = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        count_en = (state_q == ST_RUN);
    end

    // R12
    stop_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (state_q == ST_STOP));

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_sel,
    output logic             tick
);

    localparam int PS_W = 1 << PRE_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W:0]   lim_full;
    logic [PS_W-1:0] lim;
    logic            unused_msb;

    // Divide by 2^(pre+1): the fixed half-rate stage folded into the shift
    assign lim_full   = ((PS_W+1)'(1) << ({1'b0, pre_sel} + 1'b1)) - (PS_W+1)'(1);
    assign lim        = lim_full[PS_W-1:0];
    assign unused_msb = lim_full[PS_W];

    assign tick = count_en && (ps_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (restart) begin
            ps_q <= '0;
        end else if (count_en) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
        end
    end

    // R12
    ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !restart) |=> $stable(ps_q));

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ow_load,
    input  logic [CNT_W-1:0] ow_val,
    input  logic             rld,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tc
);

    localparam logic [CNT_W-1:0] WRAP_VAL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = rld ? mod_val : WRAP_VAL;
    assign tc     = tick && (cnt_q == '0);
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= load_val;
        end else if (ow_load) begin
            cnt_q <= ow_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    // R11
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == $past(load_val)));

    // R10
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ow_load && !restart) |=> (cnt_q == $past(ow_val)));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && rld && !restart && !ow_load) |=> (cnt_q == $past(mod_val)));

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart && !ow_load) |=> $stable(cnt_q));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              dbg_mode,
    input  logic              doze_mode,
    output logic              irq
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_nx;
    logic [CNT_W-1:0] mod_q;
    logic             restart;
    logic [CNT_W-1:0] load_val;
    logic             ow_load;
    logic             count_en;
    logic             tick;
    logic             tc;
    logic [CNT_W-1:0] cnt;

    pit_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .tc       (tc),
        .cnt      (cnt),
        .ctrl_q   (ctrl_q),
        .ctrl_nx  (ctrl_nx),
        .mod_q    (mod_q),
        .restart  (restart),
        .load_val (load_val),
        .ow_load  (ow_load),
        .irq      (irq)
    );

    pit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_nx  (ctrl_nx),
        .en_q     (ctrl_q.en),
        .dbg_pin  (dbg_mode),
        .doze_pin (doze_mode),
        .count_en (count_en)
    );

    pit_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .restart  (restart),
        .pre_sel  (ctrl_q.pre),
        .tick     (tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .load_val (load_val),
        .ow_load  (ow_load),
        .ow_val   (bus_wdata),
        .rld      (ctrl_q.rld),
        .mod_val  (mod_q),
        .cnt      (cnt),
        .tc       (tc)
    );

endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;

    localparam logic [15:0] C_EN   = 16'h0001;
    localparam logic [15:0] C_RLD  = 16'h0002;
    localparam logic [15:0] C_FLAG = 16'h0004;
    localparam logic [15:0] C_IE   = 16'h0008;
    localparam logic [15:0] C_OVW  = 16'h0010;
    localparam logic [15:0] C_DBG  = 16'h0020;
    localparam logic [15:0] C_DOZE = 16'h0040;
    localparam int          WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dbg_mode = 1'b0;
    logic        doze_mode = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    pit_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_mode  (dbg_mode),
        .doze_mode (doze_mode),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, got cycle %0d expected < %0d", cyc, WD_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [15:0] pre_field(int p);
        return 16'(p) << 8;
    endfunction

    function automatic int exp_period(int p, int m);
        return (1 << (p + 1)) * (m + 1);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_true(string req, bit ok, logic [31:0] got);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0h, outside expected range", req, got);
        end
    endtask

    // Called on a falling edge; the write is taken on the next rising edge
    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int t);
        while (!irq) @(negedge clk);
        t = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v, v2;
        int t0, t1;
        void'($urandom(32'h1234_5eed));

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 16'h0);
        rd(3'd2, v); check("R1 mod", v, 16'h0);
        rd(3'd4, v); check("R1 cnt", v, 16'h0);
        check("R1 irq", irq, 1'b0);

        // R2 count is read-only, reserved bits and offset 6 read zero
        wr(3'd4, 16'h5555);
        rd(3'd4, v); check("R2 count write ignored", v, 16'h0);
        wr(3'd0, 16'hF080);
        rd(3'd0, v); check("R2 reserved bits", v, 16'h0);
        rd(3'd6, v); check("R2 unused offset", v, 16'h0);

        // R7 a write cannot set the flag
        wr(3'd0, C_FLAG);
        rd(3'd0, v); check("R7 flag not settable", v, 16'h0);

        // R14 terminal step and clear on the same edge, mod=2, prescale 0
        wr(3'd2, 16'd2);
        wr(3'd0, C_EN | C_RLD);                 // restart at edge k
        idle(5);
        wr(3'd0, C_EN | C_RLD | C_FLAG);        // lands on edge k+6
        rd(3'd0, v); check("R14 flag kept", v[2], 1'b1);
        check("R8 irq low with ie=0", irq, 1'b0);
        wr(3'd0, C_EN | C_RLD | C_FLAG);        // edge k+7, after the event
        rd(3'd0, v); check("R7 flag cleared", v[2], 1'b0);

        // R8 and R7: ie on, wait for flag, write 0 to flag keeps it
        wr(3'd0, C_EN | C_RLD | C_IE);
        wait_irq(t0);
        check("R8 irq high", irq, 1'b1);
        wr(3'd0, C_EN | C_RLD | C_IE);
        rd(3'd0, v); check("R7 zero write keeps flag", v[2], 1'b1);
        wr(3'd0, C_EN | C_RLD);
        check("R8 irq follows ie", irq, 1'b0);
        // R9 modulus write clears flag
        wr(3'd2, 16'd200);
        rd(3'd0, v); check("R9 mod write clears flag", v[2], 1'b0);
        wr(3'd0, 16'h0);

        // R3 and R4 periods under random prescale and modulus
        for (int i = 0; i < 8; i++) begin
            int p, m;
            p = $urandom_range(0, 3);
            m = $urandom_range(2, 40);
            wr(3'd0, 16'h0);
            wr(3'd2, 16'(m));
            wr(3'd0, C_EN | C_RLD | C_IE | pre_field(p));
            wait_irq(t0);
            rd(3'd4, v);
            check_true("R4 count at most modulus", v <= 16'(m), {16'h0, v});
            wr(3'd0, C_EN | C_RLD | C_IE | C_FLAG | pre_field(p));
            wait_irq(t1);
            check("R3 R4 period", t1 - t0, exp_period(p, m));
        end

        // R10 no overwrite: new modulus waits for reload
        wr(3'd0, 16'h0);
        wr(3'd2, 16'd100);
        wr(3'd0, C_EN | C_RLD | C_IE);
        wait_irq(t0);
        wr(3'd0, C_EN | C_RLD | C_IE | C_FLAG);
        wr(3'd2, 16'd5);
        rd(3'd4, v);
        check_true("R10 no immediate load", v > 16'd50, {16'h0, v});
        wait_irq(t0);
        wr(3'd0, C_EN | C_RLD | C_IE | C_FLAG);
        wait_irq(t1);
        check("R10 new modulus at reload", t1 - t0, exp_period(0, 5));

        // R10 overwrite loads at once
        wr(3'd0, C_EN | C_RLD | C_OVW);
        wr(3'd2, 16'd7);
        rd(3'd4, v); check("R10 overwrite load", v, 16'd7);

        // R5 free-running wrap to 0xFFFF
        wr(3'd0, C_EN | C_OVW | C_IE);
        rd(3'd4, v); check("R5 restart loads ffff", v, 16'hFFFF);
        wr(3'd2, 16'd3);
        rd(3'd4, v); check("R10 overwrite in free mode", v, 16'd3);
        wait_irq(t0);
        rd(3'd4, v);
        check_true("R5 wrap to ffff", v >= 16'hFFF0, {16'h0, v});

        // R11 ie-only change keeps count; other change restarts (prescale 15)
        wr(3'd0, 16'h0);
        wr(3'd0, C_EN | C_OVW | pre_field(15));
        wr(3'd2, 16'h1234);
        wr(3'd0, C_EN | C_OVW | C_IE | pre_field(15));
        rd(3'd4, v); check("R11 ie toggle keeps count", v, 16'h1234);
        wr(3'd0, C_EN | C_OVW | C_DBG | pre_field(15));
        rd(3'd4, v); check("R11 config change restarts", v, 16'hFFFF);

        // R12 disable freezes count
        wr(3'd0, 16'h0);
        wr(3'd2, 16'd1000);
        wr(3'd0, C_EN | C_RLD);
        idle(30);
        wr(3'd0, C_RLD);
        rd(3'd4, v); idle(20); rd(3'd4, v2);
        check("R12 frozen count", v2, v);

        // R13 debug halt
        wr(3'd0, C_EN | C_RLD | C_DBG);
        dbg_mode = 1'b1;
        idle(2);
        rd(3'd4, v); idle(20); rd(3'd4, v2);
        check("R13 debug halt holds", v2, v);
        dbg_mode = 1'b0;
        idle(2);
        rd(3'd4, v); idle(20); rd(3'd4, v2);
        check_true("R13 resumes after debug", v2 != v, {16'h0, v2});
        // R13 doze halt
        wr(3'd0, C_EN | C_RLD | C_DOZE);
        doze_mode = 1'b1;
        idle(2);
        rd(3'd4, v); idle(20); rd(3'd4, v2);
        check("R13 doze halt holds", v2, v);
        // R13 pin without bit has no effect
        dbg_mode = 1'b1;
        wr(3'd0, C_EN | C_RLD);
        idle(2);
        rd(3'd4, v); idle(20); rd(3'd4, v2);
        check_true("R13 pin without bit counts", v2 != v, {16'h0, v2});
        dbg_mode = 1'b0;
        doze_mode = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule